// File: doc/BRIEF.md
# DRAM Refresh Requester

This block keeps dynamic memory alive without processor help. A programmable period counter counts clock cycles. Each time a period ends, it adds one to a small backlog of owed refreshes. While the backlog is non-zero, the block raises a bus request. When the arbiter grants the bus, the block starts a refresh cycle and presents the current row number. When the memory side reports the cycle finished, the block releases the bus, settles one owed refresh and steps the row number.

Software sets the period and an enable flag through a two-entry write port. A period of zero stops new refreshes. Clearing the enable flag drops any refreshes still owed and holds the period counter at its start. Row strobe timing and chip-select decoding belong to the memory controller that watches the strobe.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset `bus_req`, `rfsh_strobe` and `rfsh_row` are all zero, the period is zero and refresh is disabled.
- R2: With a period of N (N ≥ 1) and refresh enabled, `bus_req` first rises N+1 clock edges after the edge that captured the enable write. Writing the period restarts the count.
- R3: A period of zero produces no refresh request, even while enabled.
- R4: Once raised, `bus_req` stays high until a refresh cycle completes, unless refresh is disabled first. `rfsh_strobe` is never high without `bus_req`.
- R5: `rfsh_strobe` rises on the edge after the one that samples `bus_gnt` high while requesting, and not before a grant.
- R6: `rfsh_strobe` stays high until `rfsh_done` is sampled high. On that edge `bus_req` and `rfsh_strobe` both fall.
- R7: `rfsh_row` (13 bits) increases by exactly one per completed refresh cycle, wraps from 0x1FFF to 0, and is otherwise unchanged.
- R8: Period expiries that arrive while refreshes are still owed are counted, up to 7 owed in total. Each owed refresh produces one refresh cycle.
- R9: Writing the enable flag low clears all owed refreshes and holds the period counter at its start. A request not yet granted is withdrawn within two edges, and no new request appears while disabled.
- R10: Write address 0 loads the 16-bit period from `cfg_wdata`. Write address 1 sets the enable flag from `cfg_wdata` bit 0. All other data bits at address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = period, 1 = enable flag |
| cfg_wdata | input | 16 | Write data |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rfsh_strobe | output | 1 | Refresh cycle in progress |
| rfsh_done | input | 1 | Refresh cycle finished |
| rfsh_row | output | 13 | Row to refresh |

## Verification
The main path is tried with a range of periods, including the shortest period of one. Each is combined with different grant delays and completion delays. This separates an off-by-one in the period count from a slip in the request, strobe or release timing. A period of one makes expiries pile up during service, and a long-withheld grant fills the backlog. Counting the cycles that follow shows whether saturation at seven holds and whether every owed refresh is served. A run of more than 8192 completions exposes a wrong wrap of the row number. Disabling mid-request and writes with bit 0 clear show that the enable flag gates the request path.

// File: rtl/refresh_pkg.sv
// Shared types for the DRAM refresh requester.
package refresh_pkg;
    // Sequencer phases: idle, waiting for bus grant, refresh cycle running
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ASK   = 2'd1,
        PH_CYCLE = 2'd2
    } rfsh_phase_t;

    // Configuration write addresses
    localparam logic ADDR_PERIOD = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/rfsh_cfg_regs.sv
// Configuration registers: period value and enable flag.
// Assumes single-cycle write strobes; gives a restart pulse on period writes.
module rfsh_cfg_regs
    import refresh_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [PERIOD_W-1:0] cfg_wdata,
    output logic [PERIOD_W-1:0] period,
    output logic                enable,
    output logic                period_wr
);
    // Capture period and enable writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            enable <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_PERIOD) period <= cfg_wdata;
            else                         enable <= cfg_wdata[0];
        end
    end

    // Restart request for the period counter on a period write
    assign period_wr = cfg_we && (cfg_addr == ADDR_PERIOD);
endmodule

// File: rtl/rfsh_interval_timer.sv
// Period counter: pulses tick once every `period` cycles while running.
// Runs only when enabled with a non-zero period; otherwise held at start.
module rfsh_interval_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic                tick
);
    logic [PERIOD_W-1:0] count;
    logic                running;

    // Running condition and expiry detection
    assign running = enable && (period != '0);
    assign tick    = running && (count == period - 1'b1);

    // Count up and wrap to zero on expiry, hold at zero when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (!running || restart) count <= '0;
        else if (tick)               count <= '0;
        else                         count <= count + 1'b1;
    end
endmodule

// File: rtl/rfsh_backlog.sv
// Saturating counter of owed refreshes.
// A tick adds one and a completion removes one; both together cancel.
module rfsh_backlog #(
    parameter int OWED_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic take,
    output logic owed_nz
);
    localparam logic [OWED_W-1:0] OWED_MAX = {OWED_W{1'b1}};

    logic [OWED_W-1:0] owed;
    logic              add;
    logic              sub;

    // Resolve simultaneous add and remove
    assign sub = take && (owed != '0);
    assign add = tick && (owed != OWED_MAX);

    // Update the owed count
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  owed <= '0;
        else if (add && !sub) owed <= owed + 1'b1;
        else if (sub && !tick) owed <= owed - 1'b1;
    end

    // Flag for the sequencer
    assign owed_nz = (owed != '0);
endmodule

// File: rtl/rfsh_row_counter.sv
// Row address counter: steps by one per completed refresh, wraps naturally.
module rfsh_row_counter #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    // Advance the row on each completion
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
// DRAM refresh requester top: period counter, owed-refresh backlog,
// bus handshake sequencer and row counter.
// Assumes the arbiter holds grant until it sees the strobe, and that
// rfsh_done is only meaningful while rfsh_strobe is high.
module dram_refresh_ctrl
    import refresh_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int ROW_W    = 13,
    parameter int OWED_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [PERIOD_W-1:0] cfg_wdata,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic                rfsh_strobe,
    input  logic                rfsh_done,
    output logic [ROW_W-1:0]    rfsh_row
);
    logic [PERIOD_W-1:0] cfg_period;
    logic                cfg_en;
    logic                period_wr;
    logic                tick;
    logic                owed_nz;
    logic                complete;
    rfsh_phase_t         phase, phase_nx;

    rfsh_cfg_regs #(.PERIOD_W(PERIOD_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .period(cfg_period), .enable(cfg_en),
        .period_wr(period_wr)
    );

    rfsh_interval_timer #(.PERIOD_W(PERIOD_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .enable(cfg_en), .period(cfg_period),
        .restart(period_wr), .tick(tick)
    );

    rfsh_backlog #(.OWED_W(OWED_W)) i_backlog (
        .clk(clk), .rst_n(rst_n), .clear(!cfg_en), .tick(tick),
        .take(complete), .owed_nz(owed_nz)
    );

    rfsh_row_counter #(.ROW_W(ROW_W)) i_row (
        .clk(clk), .rst_n(rst_n), .step(complete), .row(rfsh_row)
    );

    // A refresh cycle finishes when done is seen during the strobe
    assign complete = (phase == PH_CYCLE) && rfsh_done;

    // Next-phase selection for the bus handshake
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (cfg_en && owed_nz) phase_nx = PH_ASK;
            PH_ASK:   if (!cfg_en)           phase_nx = PH_IDLE;
                      else if (bus_gnt)      phase_nx = PH_CYCLE;
            PH_CYCLE: if (rfsh_done)         phase_nx = PH_IDLE;
            default:                         phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Handshake outputs decoded from the registered phase
    assign bus_req     = (phase != PH_IDLE);
    assign rfsh_strobe = (phase == PH_CYCLE);
endmodule

// File: rtl/refresh_checker.sv
// Timing properties of the refresh requester, bound to its top.
module refresh_checker #(
    parameter int PERIOD_W = 16,
    parameter int ROW_W    = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_gnt,
    input logic                rfsh_strobe,
    input logic                rfsh_done,
    input logic [ROW_W-1:0]    rfsh_row,
    input logic                en,
    input logic                tick,
    input logic                owed_nz,
    input logic [PERIOD_W-1:0] period
);
    p_zero_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !tick);

    p_strobe_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_strobe |-> bus_req);

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !rfsh_strobe && en) |=> bus_req);

    p_strobe_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_strobe) |-> $past(bus_gnt) && $past(bus_req));

    p_cycle_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_strobe && !rfsh_done) |=> rfsh_strobe);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_strobe && rfsh_done) |=> !bus_req);

    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_strobe && rfsh_done) |=> rfsh_row == ROW_W'($past(rfsh_row) + 1'b1));

    p_row_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfsh_strobe && rfsh_done) |=> $stable(rfsh_row));

    p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !owed_nz);

    p_off_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !bus_req) |=> !bus_req);
endmodule

bind dram_refresh_ctrl refresh_checker #(.PERIOD_W(PERIOD_W), .ROW_W(ROW_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rfsh_strobe(rfsh_strobe), .rfsh_done(rfsh_done), .rfsh_row(rfsh_row),
    .en(cfg_en), .tick(tick), .owed_nz(owed_nz), .period(cfg_period)
);

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // Each vector: {period[15:0], grant delay[7:0], done delay[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd3,  8'd0, 8'd0},
        {16'd5,  8'd2, 8'd1},
        {16'd1,  8'd0, 8'd3},
        {16'd8,  8'd4, 8'd0},
        {16'd2,  8'd1, 8'd2},
        {16'd16, 8'd0, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_gnt = 1'b0;
    logic        rfsh_done = 1'b0;
    logic        bus_req;
    logic        rfsh_strobe;
    logic [12:0] rfsh_row;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 0;
    logic [12:0] exp_row = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_ctrl i_dram_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .rfsh_strobe(rfsh_strobe), .rfsh_done(rfsh_done), .rfsh_row(rfsh_row)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Serve every request with immediate grant; return completions seen
    task automatic serve(output int done_cnt);
        int quiet = 0;
        done_cnt = 0;
        bus_gnt = 1'b1;
        for (int i = 0; i < 400 && quiet < 20; i++) begin
            if (rfsh_strobe) begin
                rfsh_done = 1'b1; step(); rfsh_done = 1'b0;
                done_cnt++; exp_row++; quiet = 0;
            end else begin
                quiet = bus_req ? 0 : quiet + 1;
                step();
            end
        end
        bus_gnt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int cnt;
        int got;
        repeat (3) step();
        // R1: reset state
        check(bus_req == 0 && rfsh_strobe == 0, "R1 handshake idle", bus_req, 0);
        check(rfsh_row == 0, "R1 row", rfsh_row, 0);
        rst_n = 1'b1;
        step();

        // R3: zero period never requests
        wr(1'b1, 16'h0001);
        cnt = 0;
        repeat (50) begin step(); if (bus_req) cnt++; end
        check(cnt == 0, "R3 zero period", cnt, 0);
        wr(1'b1, 16'h0000);

        // R10: bit 0 clear at address 1 does not enable
        wr(1'b0, 16'd2);
        wr(1'b1, 16'hFFFE);
        cnt = 0;
        repeat (20) begin step(); if (bus_req) cnt++; end
        check(cnt == 0, "R10 enable bit only", cnt, 0);

        // Vector walk: R2, R4, R5, R6, R7, R9
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] per = VEC[v][31:16];
            int gd = int'(VEC[v][15:8]);
            int dd = int'(VEC[v][7:0]);
            wr(1'b0, per);
            wr(1'b1, 16'h0001);
            cnt = 0;
            while (!bus_req && cnt < 100) begin step(); cnt++; end
            check(cnt == int'(per) + 1, "R2 first request delay", cnt, int'(per) + 1);
            for (int g = 0; g < gd; g++) begin
                step();
                check(bus_req && !rfsh_strobe, "R4 request held without grant", rfsh_strobe, 0);
            end
            bus_gnt = 1'b1; step(); bus_gnt = 1'b0;
            check(rfsh_strobe == 1, "R5 strobe after grant", rfsh_strobe, 1);
            for (int d = 0; d < dd; d++) begin
                step();
                check(rfsh_strobe == 1, "R6 strobe held until done", rfsh_strobe, 1);
            end
            rfsh_done = 1'b1; step(); rfsh_done = 1'b0;
            exp_row++;
            check(bus_req == 0, "R6 release after done", bus_req, 0);
            check(rfsh_row == exp_row, "R7 row step", rfsh_row, exp_row);
            wr(1'b1, 16'h0000);
            step();
            check(bus_req == 0, "R9 request withdrawn", bus_req, 0);
            cnt = 0;
            repeat (10) begin step(); if (bus_req) cnt++; end
            check(cnt == 0, "R9 quiet while disabled", cnt, 0);
        end

        // R8: backlog saturates at seven owed refreshes
        wr(1'b0, 16'd2);
        wr(1'b1, 16'h0001);
        repeat (40) step();
        wr(1'b0, 16'd0);
        serve(got);
        check(got == 7, "R8 backlog served count", got, 7);
        check(rfsh_row == exp_row, "R7 row after backlog", rfsh_row, exp_row);
        wr(1'b1, 16'h0000);
        step();

        // R7: row wraps from 0x1FFF to 0
        wr(1'b0, 16'd1);
        wr(1'b1, 16'h0001);
        bus_gnt = 1'b1;
        for (int i = 0; i < 40000 && exp_row != 13'h1FFF; i++) begin
            if (rfsh_strobe) begin
                rfsh_done = 1'b1; step(); rfsh_done = 1'b0; exp_row++;
            end else step();
        end
        check(rfsh_row == 13'h1FFF, "R7 row top", rfsh_row, 13'h1FFF);
        cnt = 0;
        while (!rfsh_strobe && cnt < 10) begin step(); cnt++; end
        rfsh_done = 1'b1; step(); rfsh_done = 1'b0; exp_row++;
        check(rfsh_row == 0, "R7 row wrap", rfsh_row, 0);
        bus_gnt = 1'b0;

        // R9 + R1: reset while requesting clears everything
        step(); step();
        rst_n = 1'b0; step();
        check(bus_req == 0 && rfsh_strobe == 0 && rfsh_row == 0, "R1 reset mid-run", rfsh_row, 0);
        rst_n = 1'b1;
        cnt = 0;
        repeat (20) begin step(); if (bus_req) cnt++; end
        check(cnt == 0, "R1 disabled after reset", cnt, 0);

        finish_run();
    end
endmodule